// File: doc/BRIEF.md
# Burst Line Scrambler, Descrambler and Ternary Mapper

This block sits between a burst-mode subscriber loop framer and its line interface. On the transmit side each burst arrives as a stream of qualified bits. The first bit is marked as the start of the burst. That start bit goes out untouched, and every payload bit after it is whitened by a self-synchronizing 9-stage scrambler with the polynomial x^9 + x^5 + 1. The scrambled stream is then mapped to a two-bit ternary line code in which marks alternate in polarity. The start bit is always sent as a mark, so the burst boundary stays visible on the line.

The receive side takes the detected bit stream with its own start marker and removes the scrambling using the same polynomial. The descrambler shifts in the received bits, not its own output. It therefore aligns itself to the far end within nine payload bits and needs no shared seed.

Both paths register their outputs, giving one cycle from input to output. Scrambler state is kept across bursts and idle cycles and is cleared only by reset.

Top module: `burst_scr_top`

## Requirements
- R1: While reset is asserted and on the first sample after it, all valid, start and bit outputs are 0 and the line code is 00.
- R2: On each path the output valid and start flags repeat the input valid and start flags one clock later, and the output bit appears in that same cycle.
- R3: On transmit, a valid bit flagged as start is output unchanged and leaves the scrambler register unchanged.
- R4: On transmit, a valid payload bit d is output as s = d ^ q5 ^ q9, where qk is register stage k (stage 1 holds the newest). The register then shifts s in at stage 1.
- R5: Scrambler and descrambler registers hold their contents across idle cycles (valid low) and from one burst to the next. Only reset clears them.
- R6: On receive, a valid bit flagged as start is output unchanged and leaves the descrambler register unchanged.
- R7: On receive, a valid payload bit r is output as r ^ p5 ^ p9, where pk is descrambler stage k. The register then shifts r in at stage 1, so a looped-back transmit stream returns the original payload from its tenth payload bit on.
- R8: A single inverted received payload bit at position k corrupts exactly the recovered bits at positions k, k+5 and k+9 and no others.
- R9: The line code is 00 for a zero level, 01 for a positive mark and 10 for a negative mark. It is 00 whenever the transmit output is not valid or carries a 0 payload bit, and it is never 11.
- R10: Each mark has the opposite polarity of the previous mark, and the first mark after reset is positive.
- R11: A valid start bit is always mapped to a mark whatever its value, and that mark takes part in the alternation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Transmit bit qualifier |
| tx_sob_i | input | 1 | Transmit bit is the burst start bit |
| tx_bit_i | input | 1 | Transmit data bit |
| tx_valid_o | output | 1 | Scrambled bit qualifier |
| tx_sob_o | output | 1 | Scrambled bit is the start bit |
| tx_bit_o | output | 1 | Scrambled bit |
| tx_line_o | output | 2 | Ternary line code: 00 zero, 01 positive, 10 negative |
| rx_valid_i | input | 1 | Received bit qualifier |
| rx_sob_i | input | 1 | Received bit is the burst start bit |
| rx_bit_i | input | 1 | Received (scrambled) bit |
| rx_valid_o | output | 1 | Descrambled bit qualifier |
| rx_sob_o | output | 1 | Descrambled bit is the start bit |
| rx_bit_o | output | 1 | Descrambled bit |

## Verification
The hardest behaviour to reach from the ports is error propagation in the descrambler. It only shows once the descrambler register holds real line history, and then only as a pattern spread nine bits wide. The bench first runs the descrambler on a long clean stream so that its state is set. It then computes the clean recovered bits from its own copy of that state and sends the same stream with one bit inverted. It checks that exactly positions k, k+5 and k+9 differ. Loopback recovery is checked in the same way, using a transmit register that is not zero against a receive register that is cleared, so the nine-bit alignment interval is actually exercised.

// File: rtl/burst_scr_pkg.sv
package burst_scr_pkg;
  localparam int unsigned SCR_ORDER = 9;
  localparam int unsigned SCR_TAP   = 5;

  typedef enum logic [1:0] {
    LINE_ZERO = 2'b00,
    LINE_POS  = 2'b01,
    LINE_NEG  = 2'b10
  } line_code_e;
endpackage

// File: rtl/burst_lfsr.sv
module burst_lfsr #(
  parameter int unsigned ORDER      = 9,
  parameter int unsigned TAP        = 5,
  parameter bit          DESCRAMBLE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sob_i,
  input  logic bit_i,
  output logic valid_o,
  output logic sob_o,
  output logic bit_o
);
  localparam int unsigned HI = ORDER - 1;
  localparam int unsigned MID = TAP - 1;

  logic [HI:0] sr_q;
  logic        mix_c;
  logic        out_c;
  logic        fb_c;
  logic        adv_c;

  assign mix_c = bit_i ^ sr_q[MID] ^ sr_q[HI];
  assign out_c = sob_i ? bit_i : mix_c;
  assign adv_c = valid_i & ~sob_i;

  generate
    if (DESCRAMBLE) begin : g_desc
      assign fb_c = bit_i;   // self-sync: history is the line stream
    end else begin : g_scr
      assign fb_c = mix_c;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      valid_o <= 1'b0;
      sob_o   <= 1'b0;
      bit_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      sob_o   <= valid_i & sob_i;
      bit_o   <= valid_i & out_c;
      if (adv_c) sr_q <= {sr_q[HI-1:0], fb_c};
    end
  end
endmodule

// File: rtl/burst_ami_map.sv
module burst_ami_map
  import burst_scr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       sob_i,
  input  logic       bit_i,
  output logic [1:0] line_o
);
  logic pos_next_q;
  logic mark_c;
  line_code_e code_c;

  assign mark_c = valid_i & (sob_i | bit_i);

  always_comb begin
    code_c = LINE_ZERO;
    if (mark_c) code_c = pos_next_q ? LINE_POS : LINE_NEG;
  end

  assign line_o = code_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_next_q <= 1'b1;
    else if (mark_c) pos_next_q <= ~pos_next_q;
  end
endmodule

// File: rtl/burst_scr_top.sv
module burst_scr_top
  import burst_scr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_valid_i,
  input  logic       tx_sob_i,
  input  logic       tx_bit_i,
  output logic       tx_valid_o,
  output logic       tx_sob_o,
  output logic       tx_bit_o,
  output logic [1:0] tx_line_o,
  input  logic       rx_valid_i,
  input  logic       rx_sob_i,
  input  logic       rx_bit_i,
  output logic       rx_valid_o,
  output logic       rx_sob_o,
  output logic       rx_bit_o
);
  burst_lfsr #(.ORDER(SCR_ORDER), .TAP(SCR_TAP), .DESCRAMBLE(1'b0)) u_scr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(tx_valid_i), .sob_i(tx_sob_i), .bit_i(tx_bit_i),
    .valid_o(tx_valid_o), .sob_o(tx_sob_o), .bit_o(tx_bit_o)
  );

  burst_ami_map u_ami (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(tx_valid_o), .sob_i(tx_sob_o), .bit_i(tx_bit_o),
    .line_o(tx_line_o)
  );

  burst_lfsr #(.ORDER(SCR_ORDER), .TAP(SCR_TAP), .DESCRAMBLE(1'b1)) u_dsc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(rx_valid_i), .sob_i(rx_sob_i), .bit_i(rx_bit_i),
    .valid_o(rx_valid_o), .sob_o(rx_sob_o), .bit_o(rx_bit_o)
  );
endmodule

// File: rtl/burst_scr_chk.sv
module burst_scr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_valid_i,
  input logic       tx_sob_i,
  input logic       tx_bit_i,
  input logic       tx_valid_o,
  input logic       tx_sob_o,
  input logic       tx_bit_o,
  input logic [1:0] tx_line_o,
  input logic       rx_valid_i,
  input logic       rx_sob_i,
  input logic       rx_bit_i,
  input logic       rx_valid_o,
  input logic       rx_sob_o,
  input logic       rx_bit_o
);
  logic last_pos_q;
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_pos_q <= 1'b0;
      seen_q     <= 1'b0;
    end else if (tx_line_o != 2'b00) begin
      last_pos_q <= (tx_line_o == 2'b01);
      seen_q     <= 1'b1;
    end
  end

  // R2
  tx_valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |=> tx_valid_o);
  // R2
  rx_idle_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> !rx_valid_o);
  // R3
  tx_sob_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_sob_i) |=> (tx_sob_o && tx_bit_o == $past(tx_bit_i)));
  // R6
  rx_sob_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_sob_i) |=> (rx_sob_o && rx_bit_o == $past(rx_bit_i)));
  // R9
  line_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_line_o != 2'b11);
  // R9
  line_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_o |-> tx_line_o == 2'b00);
  // R10
  line_alternate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_line_o != 2'b00) |-> (seen_q ? ((tx_line_o == 2'b01) != last_pos_q)
                                     : (tx_line_o == 2'b01)));
  // R11
  sob_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_sob_o) |-> tx_line_o != 2'b00);
endmodule

bind burst_scr_top burst_scr_chk u_chk (.*);

// File: tb/burst_scr_top_test.sv
module burst_scr_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid_i = 0, tx_sob_i = 0, tx_bit_i = 0;
  logic rx_valid_i = 0, rx_sob_i = 0, rx_bit_i = 0;
  logic tx_valid_o, tx_sob_o, tx_bit_o, rx_valid_o, rx_sob_o, rx_bit_o;
  logic [1:0] tx_line_o;

  int n_chk = 0, n_bad = 0;
  logic [8:0] m_tx = '0, m_rx = '0;
  logic m_pos = 1'b1;
  logic [31:0] prng = 32'h1d2c_3b4a;

  always #10 clk = ~clk;

  burst_scr_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_valid_i(tx_valid_i), .tx_sob_i(tx_sob_i), .tx_bit_i(tx_bit_i),
    .tx_valid_o(tx_valid_o), .tx_sob_o(tx_sob_o), .tx_bit_o(tx_bit_o),
    .tx_line_o(tx_line_o),
    .rx_valid_i(rx_valid_i), .rx_sob_i(rx_sob_i), .rx_bit_i(rx_bit_i),
    .rx_valid_o(rx_valid_o), .rx_sob_o(rx_sob_o), .rx_bit_o(rx_bit_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic rnd_bit();
    prng = prng ^ (prng << 13);
    prng = prng ^ (prng >> 17);
    prng = prng ^ (prng << 5);
    return prng[0];
  endfunction

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  // one transmit bit with full output check; returns line bit
  task automatic tx_one(input logic s, input logic b, output logic sent);
    logic [1:0] ec;
    tx_valid_i = 1; tx_sob_i = s; tx_bit_i = b;
    if (s) sent = b;
    else begin
      sent = b ^ m_tx[4] ^ m_tx[8];
      m_tx = {m_tx[7:0], sent};
    end
    ec = 2'b00;
    if (s || sent) begin
      ec = m_pos ? 2'b01 : 2'b10;
      m_pos = ~m_pos;
    end
    cyc();
    chk("R2 tx valid", tx_valid_o, 1);
    chk("R2 tx sob", tx_sob_o, s);
    chk(s ? "R3 start bit" : "R4 scrambled bit", tx_bit_o, sent);
    chk(s ? "R11 start mark" : "R9/R10 line code", tx_line_o, ec);
  endtask

  task automatic rx_one(input logic s, input logic r, output logic got);
    logic e;
    rx_valid_i = 1; rx_sob_i = s; rx_bit_i = r;
    if (s) e = r;
    else begin
      e = r ^ m_rx[4] ^ m_rx[8];
      m_rx = {m_rx[7:0], r};
    end
    cyc();
    chk("R2 rx sob", rx_sob_o, s);
    chk(s ? "R6 start bit" : "R7 descrambled bit", rx_bit_o, e);
    got = rx_bit_o;
  endtask

  task automatic idle(input int n);
    tx_valid_i = 0; tx_sob_i = 0; tx_bit_i = 0;
    rx_valid_i = 0; rx_sob_i = 0; rx_bit_i = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      chk("R9 idle line zero", tx_line_o, 2'b00);
      chk("R2 idle valid", {tx_valid_o, rx_valid_o}, 2'b00);
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    #5;
    chk("R1 reset outputs", {tx_valid_o, tx_sob_o, tx_bit_o, tx_line_o,
                             rx_valid_o, rx_sob_o, rx_bit_o}, 0);
    repeat (2) @(posedge clk);
    #3 rst_n = 1;
    cyc();
    chk("R1 after reset", {tx_valid_o, tx_sob_o, tx_bit_o, tx_line_o,
                           rx_valid_o, rx_sob_o, rx_bit_o}, 0);
  endtask

  // R3 R4 R10 R11: bursts with ones, zeros and a zero-valued start bit
  task automatic t_tx_bursts();
    logic o;
    tx_one(1, 1, o);
    for (int i = 0; i < 12; i++) tx_one(0, 1, o);
    idle(3);
    tx_one(1, 0, o);            // R11 zero start bit still a mark
    for (int i = 0; i < 20; i++) tx_one(0, 0, o);
    idle(2);
    tx_one(1, 1, o);
    for (int i = 0; i < 40; i++) tx_one(0, rnd_bit(), o);
    idle(1);
  endtask

  // R5: long idle gap, state must resume
  task automatic t_gap();
    logic o;
    idle(25);
    tx_one(1, 1, o);
    for (int i = 0; i < 16; i++) tx_one(0, 0, o);   // R5 output reveals held state
    idle(1);
  endtask

  // R6 R7: transmit then loop captured line bits into the receiver
  task automatic t_loop();
    logic pay[64], line[64], o;
    tx_one(1, 1, o);
    for (int i = 0; i < 64; i++) begin
      pay[i] = rnd_bit();
      tx_one(0, pay[i], line[i]);
    end
    idle(1);
    rx_one(1, 1, o);
    for (int i = 0; i < 64; i++) begin
      rx_one(0, line[i], o);
      if (i >= 9) chk("R7 loopback payload", o, pay[i]);
    end
    idle(1);
  endtask

  // R8: single inverted bit
  task automatic t_error();
    logic c[40], clean[40], o;
    logic [8:0] st;
    int k = 15;
    rx_one(1, 0, o);
    for (int i = 0; i < 40; i++) c[i] = rnd_bit();
    st = m_rx;
    for (int i = 0; i < 40; i++) begin
      clean[i] = c[i] ^ st[4] ^ st[8];
      st = {st[7:0], c[i]};
    end
    for (int i = 0; i < 40; i++) begin
      rx_one(0, c[i] ^ (i == k), o);
      chk("R8 error spread", o, clean[i] ^ (i == k || i == k + 5 || i == k + 9));
    end
    idle(1);
    // R5 reset clears state: all-zero payload must stay zero
    t_reset();
    m_tx = '0; m_rx = '0; m_pos = 1'b1;
    tx_one(1, 0, o);
    for (int i = 0; i < 10; i++) tx_one(0, 0, o);
    idle(1);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_tx_bursts();
    t_gap();
    t_loop();
    t_error();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule